// File: doc/BRIEF.md
# Dual-Comparator Timer Module

This block is a count-up timer for a microcontroller peripheral, built 10 or 16 bits wide. Every count step comes from a one-cycle advance pulse in the system clock domain. Software picks the source of that pulse: the system clock directly, the system clock divided by four, a high-speed tick divided by 16 or 64, a timebase tick, or rising edges on an external pin. No derived clocks are created. Software never loads the counter. Raising the enable bit restarts it at zero, and a pause bit freezes it at its current value.

Two comparators watch the count. The period comparator is coarse and compares only the top 3 bits (10-bit build) or the top 8 bits (16-bit build) with a short compare value. The duty comparator compares the full width. Each comparator raises its own interrupt flag for one cycle when it matches. A select bit decides which of the two matches restarts the count. A match on the duty comparator can drive an output pin low or high, or toggle it. A polarity bit inverts the pin, and a second pin carries the complement.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the count reads 0, both flags are 0, `outPin0` equals `ctlPolarity` and `outPin1` is its complement.
- R2: On the first clock edge with `ctlEnable` high after it was low, the count becomes 0 and the divided-clock prescalers restart. While `ctlEnable` is low the count holds its value, no flag rises, and the internal output level is 0.
- R3: While `ctlPause` is high the count holds its value. Counting resumes from that value when the bit drops.
- R4: `ctlClkSel` chooses the advance source: 3'b000 system clock divided by 4 (one step per 4 edges after a restart), 3'b001 every system clock edge, 3'b010 every 16th `hsTick` pulse, 3'b011 every 64th `hsTick` pulse, 3'b100 each `tbTick` pulse. The codes 3'b101 and 3'b110 never advance the count.
- R5: Code 3'b111 advances the count once for each rising edge on `extClkPin`. The pin passes through a two-flop synchroniser first.
- R6: When the count advances from all ones and no clearing match occurs, it wraps to 0.
- R7: The period comparator matches on an advance step when the count equals `perValue` placed in the top bits with all lower bits zero. A `perValue` of 0 never matches. A match pulses `perFlag` for one cycle, and when `ctlClrSel` is 0 the count becomes 0 instead of advancing.
- R8: The duty comparator matches on an advance step when the count equals `dutyValue`. A match pulses `dutyFlag` for one cycle, and when `ctlClrSel` is 1 the count becomes 0 instead of advancing.
- R9: On a duty match `ctlOutAct` sets the output level: 2'b00 no change, 2'b01 low, 2'b10 high, 2'b11 toggle.
- R10: `outPin0` is the output level XOR `ctlPolarity`, and `outPin1` is always the inverse of `outPin0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctlEnable | input | 1 | Run enable; rising edge restarts the count |
| ctlPause | input | 1 | Freeze the count |
| ctlClkSel | input | 3 | Advance source code |
| ctlClrSel | input | 1 | 0: period match clears, 1: duty match clears |
| ctlOutAct | input | 2 | Output action on duty match |
| ctlPolarity | input | 1 | Invert output pin |
| perValue | input | PER_W | Coarse period compare value |
| dutyValue | input | CNT_W | Full-width duty compare value |
| hsTick | input | 1 | High-speed tick enable pulse |
| tbTick | input | 1 | Timebase tick enable pulse |
| extClkPin | input | 1 | Asynchronous external count pin |
| cntValue | output | CNT_W | Current count |
| perFlag | output | 1 | Period match interrupt pulse |
| dutyFlag | output | 1 | Duty match interrupt pulse |
| outPin0 | output | 1 | Output pin |
| outPin1 | output | 1 | Complementary output pin |

## Verification
The hardest states to reach are the top of the count range and a coarse period match. Both need hundreds or thousands of advance steps, and with the divided sources the result also depends on the phase of the prescaler. The stimulus reaches the wrap at 1023 and a period match at 128 by using the every-edge source. It makes the divided sources deterministic by relying on the prescaler restart at the enable rise, so the expected counts are exact floor divisions of the elapsed edges. The external pin is driven asynchronously from the falling edge, with gaps long enough that each rising edge produces exactly one step after the synchroniser.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef struct packed {
    logic cntTick;   // advance the count this edge
    logic cntClr;    // restart the count this edge
    logic outReset;  // force output level to idle
  } dct_strobe_t;

  localparam logic [2:0] SEL_SYS4 = 3'b000;
  localparam logic [2:0] SEL_SYS  = 3'b001;
  localparam logic [2:0] SEL_HS16 = 3'b010;
  localparam logic [2:0] SEL_HS64 = 3'b011;
  localparam logic [2:0] SEL_TB   = 3'b100;
  localparam logic [2:0] SEL_EXT  = 3'b111;

  localparam logic [1:0] ACT_KEEP = 2'b00;
  localparam logic [1:0] ACT_LOW  = 2'b01;
  localparam logic [1:0] ACT_HIGH = 2'b10;
  localparam logic [1:0] ACT_TOGL = 2'b11;
endpackage

// File: rtl/dct_divider.sv
module dct_divider #(
  parameter int DIV = 4,
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic inTick,
  output logic outTick
);
  logic [DIV_W-1:0] divCnt;
  logic atTop;

  assign atTop   = (divCnt == DIV_W'(DIV - 1));
  assign outTick = inTick && atTop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              divCnt <= '0;
    else if (restart)        divCnt <= '0;
    else if (inTick) begin
      if (atTop)             divCnt <= '0;
      else                   divCnt <= divCnt + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_spacing
      // R4: a divided pulse is never followed directly by another
      p_div_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        outTick |=> !outTick);
    end
  endgenerate
endmodule

// File: rtl/dct_tick_gen.sv
module dct_tick_gen #(
  parameter int SYS_DIV  = 4,
  parameter int HS_DIV_A = 16,
  parameter int HS_DIV_B = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] clkSel,
  input  logic       hsTick,
  input  logic       tbTick,
  input  logic       extClkPin,
  output logic       srcTick
);
  import dct_pkg::*;

  localparam int NUM_DIV = 3;
  localparam int DIVS [NUM_DIV] = '{SYS_DIV, HS_DIV_A, HS_DIV_B};

  logic [NUM_DIV-1:0] divIn;
  logic [NUM_DIV-1:0] divOut;
  logic extS1, extS2, extPrev, extPulse;

  assign divIn = {hsTick, hsTick, 1'b1};

  generate
    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
      dct_divider #(.DIV(DIVS[i])) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .inTick (divIn[i]),
        .outTick(divOut[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      extS1   <= 1'b0;
      extS2   <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      extS1   <= extClkPin;
      extS2   <= extS1;
      extPrev <= extS2;
    end
  end
  assign extPulse = extS2 && !extPrev;

  always_comb begin
    unique case (clkSel)
      SEL_SYS4: srcTick = divOut[0];
      SEL_SYS:  srcTick = 1'b1;
      SEL_HS16: srcTick = divOut[1];
      SEL_HS64: srcTick = divOut[2];
      SEL_TB:   srcTick = tbTick;
      SEL_EXT:  srcTick = extPulse;
      default:  srcTick = 1'b0;
    endcase
  end

  // R5: an external step pulse lasts a single cycle
  p_ext_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    extPulse |=> !extPulse);
endmodule

// File: rtl/dct_ctrl.sv
module dct_ctrl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctlEnable,
  input  logic                 ctlPause,
  input  logic                 srcTick,
  output logic                 restart,
  output dct_pkg::dct_strobe_t strobe
);
  logic enPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enPrev <= 1'b0;
    else        enPrev <= ctlEnable;
  end

  assign restart         = ctlEnable && !enPrev;
  assign strobe.cntClr   = restart;
  assign strobe.cntTick  = ctlEnable && enPrev && !ctlPause && srcTick;
  assign strobe.outReset = !ctlEnable;

  // R2: a restart can only follow a cycle with the enable low
  p_restart_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);
endmodule

// File: rtl/dct_datapath.sv
module dct_datapath #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3,
  localparam int LOW_W = CNT_W - PER_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dct_pkg::dct_strobe_t strobe,
  input  logic                 clrSel,
  input  logic [1:0]           outAct,
  input  logic                 polarity,
  input  logic [PER_W-1:0]     perValue,
  input  logic [CNT_W-1:0]     dutyValue,
  output logic [CNT_W-1:0]     cntValue,
  output logic                 perFlag,
  output logic                 dutyFlag,
  output logic                 pin0,
  output logic                 pin1
);
  import dct_pkg::*;

  logic [CNT_W-1:0] cntQ;
  logic perHit, dutyHit, clearHit, outState;

  assign perHit   = (perValue != '0) && (cntQ[CNT_W-1:LOW_W] == perValue)
                    && (cntQ[LOW_W-1:0] == '0);
  assign dutyHit  = (cntQ == dutyValue);
  assign clearHit = clrSel ? dutyHit : perHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cntQ <= '0;
    else if (strobe.cntClr)  cntQ <= '0;
    else if (strobe.cntTick) cntQ <= clearHit ? '0 : cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perFlag  <= 1'b0;
      dutyFlag <= 1'b0;
    end else begin
      perFlag  <= strobe.cntTick && perHit;
      dutyFlag <= strobe.cntTick && dutyHit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          outState <= 1'b0;
    else if (strobe.outReset)            outState <= 1'b0;
    else if (strobe.cntTick && dutyHit) begin
      unique case (outAct)
        ACT_LOW:  outState <= 1'b0;
        ACT_HIGH: outState <= 1'b1;
        ACT_TOGL: outState <= !outState;
        default:  outState <= outState;
      endcase
    end
  end

  assign cntValue = cntQ;
  assign pin0     = outState ^ polarity;
  assign pin1     = !pin0;

  p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.cntClr |=> (cntValue == '0));
  p_out_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.outReset |=> (pin0 == polarity));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.cntTick && !strobe.cntClr) |=> $stable(cntValue));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.cntTick && !strobe.cntClr && (cntQ == '1)) |=> (cntValue == '0));
  p_per_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.cntTick && !strobe.cntClr && !clrSel && perHit)
      |=> (cntValue == '0) && perFlag);
  p_duty_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.cntTick && !strobe.cntClr && clrSel && dutyHit)
      |=> (cntValue == '0) && dutyFlag);
  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.cntTick && dutyHit && (outAct == ACT_TOGL) && !strobe.outReset)
      |=> (outState != $past(outState)));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int CNT_W    = 10,
  parameter int PER_W    = (CNT_W == 16) ? 8 : 3,
  parameter int SYS_DIV  = 4,
  parameter int HS_DIV_A = 16,
  parameter int HS_DIV_B = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctlEnable,
  input  logic             ctlPause,
  input  logic [2:0]       ctlClkSel,
  input  logic             ctlClrSel,
  input  logic [1:0]       ctlOutAct,
  input  logic             ctlPolarity,
  input  logic [PER_W-1:0] perValue,
  input  logic [CNT_W-1:0] dutyValue,
  input  logic             hsTick,
  input  logic             tbTick,
  input  logic             extClkPin,
  output logic [CNT_W-1:0] cntValue,
  output logic             perFlag,
  output logic             dutyFlag,
  output logic             outPin0,
  output logic             outPin1
);
  import dct_pkg::*;

  logic        srcTick;
  logic        restart;
  dct_strobe_t strobe;

  dct_tick_gen #(
    .SYS_DIV(SYS_DIV), .HS_DIV_A(HS_DIV_A), .HS_DIV_B(HS_DIV_B)
  ) tick_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .clkSel(ctlClkSel),
    .hsTick(hsTick), .tbTick(tbTick), .extClkPin(extClkPin),
    .srcTick(srcTick)
  );

  dct_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .ctlEnable(ctlEnable), .ctlPause(ctlPause),
    .srcTick(srcTick), .restart(restart), .strobe(strobe)
  );

  dct_datapath #(.CNT_W(CNT_W), .PER_W(PER_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .clrSel(ctlClrSel),
    .outAct(ctlOutAct), .polarity(ctlPolarity), .perValue(perValue),
    .dutyValue(dutyValue), .cntValue(cntValue), .perFlag(perFlag),
    .dutyFlag(dutyFlag), .pin0(outPin0), .pin1(outPin1)
  );
endmodule

// File: tb/dual_cmp_timer_tb_top.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb_top;
  localparam int CNT_W = 10;
  localparam int PER_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctlEnable = 1'b0, ctlPause = 1'b0, ctlClrSel = 1'b0, ctlPolarity = 1'b0;
  logic [2:0] ctlClkSel = 3'b001;
  logic [1:0] ctlOutAct = 2'b00;
  logic [PER_W-1:0] perValue = '0;
  logic [CNT_W-1:0] dutyValue = '0;
  logic hsTick = 1'b1, tbTick = 1'b0, extClkPin = 1'b0;
  logic [CNT_W-1:0] cntValue;
  logic perFlag, dutyFlag, outPin0, outPin1;

  int checks = 0;
  int errors = 0;
  int dutySeen = 0;
  int perSeen = 0;

  always #4 clk = !clk;

  dual_cmp_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctlEnable(ctlEnable), .ctlPause(ctlPause),
    .ctlClkSel(ctlClkSel), .ctlClrSel(ctlClrSel), .ctlOutAct(ctlOutAct),
    .ctlPolarity(ctlPolarity), .perValue(perValue), .dutyValue(dutyValue),
    .hsTick(hsTick), .tbTick(tbTick), .extClkPin(extClkPin),
    .cntValue(cntValue), .perFlag(perFlag), .dutyFlag(dutyFlag),
    .outPin0(outPin0), .outPin1(outPin1)
  );

  always @(negedge clk) begin
    if (dutyFlag) dutySeen++;
    if (perFlag)  perSeen++;
  end

  typedef struct packed {
    logic [2:0]  sel;
    logic        clr;
    logic [2:0]  per;
    logic [9:0]  duty;
    logic [1:0]  act;
    logic        pol;
    logic [15:0] k;
    logic [9:0]  expCnt;
    logic        expPin;
    logic [3:0]  expFlags;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 1'b1, 3'd0, 10'd5,    2'd3, 1'b0, 16'd3,   10'd3,  1'b0, 4'd0}, // R8 before match
    '{3'd1, 1'b1, 3'd0, 10'd5,    2'd3, 1'b0, 16'd6,   10'd0,  1'b1, 4'd1}, // R8 R9 toggle
    '{3'd1, 1'b1, 3'd0, 10'd5,    2'd3, 1'b0, 16'd13,  10'd1,  1'b0, 4'd2}, // R8 R9 two periods
    '{3'd1, 1'b1, 3'd0, 10'd5,    2'd2, 1'b1, 16'd6,   10'd0,  1'b0, 4'd1}, // R9 high, R10 pol
    '{3'd1, 1'b1, 3'd0, 10'd3,    2'd1, 1'b1, 16'd4,   10'd0,  1'b1, 4'd1}, // R9 low, R10 pol
    '{3'd1, 1'b0, 3'd1, 10'd1000, 2'd0, 1'b0, 16'd129, 10'd0,  1'b0, 4'd0}, // R7 clear at 128
    '{3'd1, 1'b0, 3'd1, 10'd1000, 2'd0, 1'b0, 16'd131, 10'd2,  1'b0, 4'd0}, // R7 after clear
    '{3'd1, 1'b0, 3'd1, 10'd2,    2'd3, 1'b0, 16'd10,  10'd10, 1'b1, 4'd1}, // R8 flag w/o clear
    '{3'd0, 1'b1, 3'd0, 10'd1000, 2'd0, 1'b0, 16'd40,  10'd10, 1'b0, 4'd0}, // R4 sys/4
    '{3'd2, 1'b1, 3'd0, 10'd1000, 2'd0, 1'b0, 16'd160, 10'd10, 1'b0, 4'd0}, // R4 hs/16
    '{3'd3, 1'b1, 3'd0, 10'd1000, 2'd0, 1'b0, 16'd130, 10'd2,  1'b0, 4'd0}, // R4 hs/64
    '{3'd5, 1'b1, 3'd0, 10'd1000, 2'd0, 1'b0, 16'd20,  10'd0,  1'b0, 4'd0}, // R4 reserved
    '{3'd6, 1'b1, 3'd0, 10'd1000, 2'd0, 1'b0, 16'd20,  10'd0,  1'b0, 4'd0}  // R4 reserved
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  // Restart the timer with a configuration, then let k edges pass after the restart edge.
  task automatic run(input logic [2:0] sel, input logic clr, input logic [2:0] per,
                     input logic [9:0] duty, input logic [1:0] act, input logic pol,
                     input int k);
    @(negedge clk);
    ctlEnable = 1'b0; ctlPause = 1'b0;
    ctlClkSel = sel; ctlClrSel = clr; perValue = per; dutyValue = duty;
    ctlOutAct = act; ctlPolarity = pol;
    @(negedge clk);
    ctlEnable = 1'b1;
    dutySeen = 0; perSeen = 0;
    repeat (k + 1) @(posedge clk);
    settle();
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(cntValue), 0);
    chk("R1 flags", int'({perFlag, dutyFlag}), 0);
    chk("R1 pin0", int'(outPin0), 0);
    chk("R1 pin1", int'(outPin1), 1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].sel, VECS[i].clr, VECS[i].per, VECS[i].duty,
          VECS[i].act, VECS[i].pol, int'(VECS[i].k));
      chk($sformatf("R4/R7/R8 vec%0d count", i), int'(cntValue), int'(VECS[i].expCnt));
      chk($sformatf("R9/R10 vec%0d pin0", i), int'(outPin0), int'(VECS[i].expPin));
      chk($sformatf("R8 vec%0d duty flags", i), dutySeen, int'(VECS[i].expFlags));
      chk($sformatf("R10 vec%0d pin1", i), int'(outPin1), int'(!VECS[i].expPin));
    end

    // R7 period flag pulses once at 128
    run(3'd1, 1'b0, 3'd1, 10'd1000, 2'd0, 1'b0, 129);
    chk("R7 period flag count", perSeen, 1);

    // R6 wrap with period value zero (never matches, R7)
    run(3'd1, 1'b0, 3'd0, 10'd0, 2'd0, 1'b0, 1023);
    chk("R6 top of range", int'(cntValue), 1023);
    run(3'd1, 1'b0, 3'd0, 10'd0, 2'd0, 1'b0, 1025);
    chk("R6 wrapped", int'(cntValue), 1);
    chk("R7 zero period no flag", perSeen, 0);

    // R3 pause
    run(3'd1, 1'b1, 3'd0, 10'd1000, 2'd0, 1'b0, 5);
    chk("R3 before pause", int'(cntValue), 5);
    ctlPause = 1'b1;
    repeat (10) @(posedge clk);
    settle();
    chk("R3 held", int'(cntValue), 5);
    ctlPause = 1'b0;
    repeat (3) @(posedge clk);
    settle();
    chk("R3 resumed", int'(cntValue), 8);

    // R2 enable low freezes count and idles output, rise restarts
    run(3'd1, 1'b1, 3'd0, 10'd5, 2'd3, 1'b0, 8);
    chk("R2 running count", int'(cntValue), 2);
    chk("R2 running pin", int'(outPin0), 1);
    ctlEnable = 1'b0;
    repeat (4) @(posedge clk);
    settle();
    chk("R2 frozen count", int'(cntValue), 2);
    chk("R2 idle pin", int'(outPin0), 0);
    ctlEnable = 1'b1;
    @(posedge clk);
    settle();
    chk("R2 restart zero", int'(cntValue), 0);

    // R5 external pin edges
    run(3'd7, 1'b1, 3'd0, 10'd1000, 2'd0, 1'b0, 2);
    chk("R5 no edges", int'(cntValue), 0);
    for (int e = 0; e < 6; e++) begin
      @(negedge clk); extClkPin = 1'b1;
      repeat (3) @(negedge clk);
      extClkPin = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (5) @(posedge clk);
    settle();
    chk("R5 six edges", int'(cntValue), 6);

    // R4 timebase pulses
    run(3'd4, 1'b1, 3'd0, 10'd1000, 2'd0, 1'b0, 3);
    chk("R4 timebase idle", int'(cntValue), 0);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); tbTick = 1'b1;
      @(negedge clk); tbTick = 1'b0;
      @(negedge clk);
    end
    settle();
    chk("R4 timebase five", int'(cntValue), 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule